// File: doc/BRIEF.md
# Preamble Control-Header Inserter

This block sits on the transmit side of a byte-wide stream, between the MAC and the PHY-facing serializer. Each frame arrives with an ordinary 8-byte preamble. The block overwrites those 8 bytes with a typed control header and leaves the frame's length unchanged. The header carries a packet type, a subport number from configuration and an extension type. When the timestamp extension is active, it also carries the 32-bit value of a local quarter-nanosecond time counter. That value is sampled in the cycle in which the frame's first byte is accepted. A CRC-8 over the header body closes the header. All frame bytes after the preamble pass through unchanged, and each output byte appears one cycle after its input byte.

Between frames, a one-cycle idle request makes the block send a stand-alone 8-byte idle header with no data after it. Two separate strobes turn the timestamp extension on and off. The change is applied only in a cycle with no frame or idle header in flight, and an output flag reports the extension that is in force. The subport and plain-mode inputs are sampled once, at the first byte of a frame.

Top module: `pch_inserter`

## Requirements
- R1: After reset, outValid, outSop, outLast and extActive are all 0.
- R2: An accepted input byte appears on outData one cycle later with outValid high. Input bytes 0 to 7 of a frame, counted in accepted bytes so that gaps in inValid are allowed, are replaced by header bytes 0 to 7. Header byte 0 is the start byte 0xFB. Every byte from input byte 8 onward is forwarded unchanged.
- R3: With the extension active and plain mode off, control byte 1 has type 00 and extension type 01. Byte 2 is 0x00, and bytes 3 to 6 hold the timeQ value of the cycle that accepted the frame's first byte, most significant byte first.
- R4: With the extension inactive and plain mode off, the control byte has type 00 and extension type 00, and bytes 2 to 6 are zero.
- R5: With cfgPlain high at frame start, the control byte has type 01 and extension type 00, and bytes 2 to 6 are zero, whatever the state of extActive.
- R6: Header byte 7 is a CRC-8 over header bytes 1 to 6. The polynomial is x^8+x^2+x+1 (0x07), the initial value is 0x00, and bits are processed most significant first.
- R7: The control byte packs the type in bits [7:6], the subport in bits [5:2] and the extension type in bits [1:0]. The subport is cfgSubport modulo SUBPORTS (default 8).
- R8: extEnStb sets the extension request and extDisStb clears it, with enable winning when both are high. extActive takes the request value only in a cycle with no frame in progress, no idle header being sent and no input byte present, and it holds during a frame.
- R9: An idleReq pulse in a quiet cycle produces exactly 8 output bytes: byte 0 is 0xFB, the type is 10, the extension type is 00, bytes 2 to 6 are zero and byte 7 is the CRC. An idleReq while a frame is in progress is ignored.
- R10: Changes to cfgSubport or cfgPlain after a frame's first byte do not alter that frame's header.
- R11: outSop is high only on header byte 0. outLast mirrors inLast for frames and is high on byte 7 of an idle header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input byte present |
| inData | input | 8 | Input byte, standard preamble first |
| inLast | input | 1 | Final byte of the input frame |
| idleReq | input | 1 | Request a stand-alone idle header |
| cfgSubport | input | 4 | Configured subport number |
| cfgPlain | input | 1 | Send header type "no control header" |
| extEnStb | input | 1 | Strobe that requests the timestamp extension |
| extDisStb | input | 1 | Strobe that withdraws the timestamp extension |
| timeQ | input | 32 | Local time, nanoseconds times four |
| outValid | output | 1 | Output byte present |
| outData | output | 8 | Output byte |
| outSop | output | 1 | Marks header byte 0 |
| outLast | output | 1 | Final byte of a frame or idle header |
| extActive | output | 1 | Timestamp extension currently applied |

## Verification
The assertions rely on the input side keeping to a few rules. No input byte arrives while an idle header is being sent. Every frame is longer than its 8-byte preamble, so inLast never falls inside the header. The subport range check also relies on SUBPORTS being a power of two no larger than 16. The bench keeps within these rules: it issues idle requests only after the stream has been quiet for several cycles, sends frames of at least 12 bytes, and does not start a new frame until the previous output has drained. Idle requests and configuration changes made in the middle of a frame fall on data already covered by the same rules.

// File: rtl/pch_pkg.sv
package pch_pkg;

  localparam int HDR_BYTES = 8;

  typedef enum logic [1:0] {
    PT_HDR   = 2'b00,
    PT_NOHDR = 2'b01,
    PT_IDLE  = 2'b10,
    PT_RSVD  = 2'b11
  } pktType_e;

  typedef enum logic [1:0] {
    EXT_NONE = 2'b00,
    EXT_TS   = 2'b01
  } extType_e;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic       start;    // build and latch a fresh header
    logic       idle;     // header being built is an idle header
    logic       emit;     // an output byte leaves next cycle
    logic       hdrByte;  // output byte comes from the header
    logic [2:0] byteIdx;  // header byte index
    logic       last;     // output byte is the final one
  } ctrlStb_t;

  // one byte step of CRC-8, polynomial 0x07, MSB first
  function automatic logic [7:0] crc8Step(logic [7:0] crc, logic [7:0] d);
    logic [7:0] c;
    c = crc ^ d;
    for (int b = 0; b < 8; b++) begin
      c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/pch_ctrl.sv
module pch_ctrl
  import pch_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inLast,
  input  logic     idleReq,
  input  logic     extEnStb,
  input  logic     extDisStb,
  output ctrlStb_t stb,
  output logic     extActive
);

  localparam int CNT_W = $clog2(HDR_BYTES + 1);
  localparam logic [CNT_W-1:0] PRE_MAX = CNT_W'(HDR_BYTES);

  logic             inFrame;
  logic             idleBusy;
  logic             extReq;
  logic [CNT_W-1:0] preCnt;
  logic [2:0]       idleCnt;
  logic             quiet;
  logic             frameStart;
  logic             idleStart;
  logic             inPre;

  assign quiet      = !inFrame && !idleBusy;
  assign frameStart = inValid && quiet;
  assign idleStart  = idleReq && quiet && !inValid;
  assign inPre      = inFrame ? (preCnt < PRE_MAX) : 1'b1;

  always_comb begin
    stb = '0;
    if (idleBusy) begin
      stb.emit    = 1'b1;
      stb.hdrByte = 1'b1;
      stb.idle    = 1'b1;
      stb.byteIdx = idleCnt;
      stb.last    = (idleCnt == 3'd7);
    end else if (idleStart) begin
      stb.start   = 1'b1;
      stb.idle    = 1'b1;
      stb.emit    = 1'b1;
      stb.hdrByte = 1'b1;
    end else if (inValid) begin
      stb.start   = frameStart;
      stb.emit    = 1'b1;
      stb.hdrByte = inPre;
      stb.byteIdx = inFrame ? preCnt[2:0] : 3'd0;
      stb.last    = inLast;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame   <= 1'b0;
      idleBusy  <= 1'b0;
      extReq    <= 1'b0;
      extActive <= 1'b0;
      preCnt    <= '0;
      idleCnt   <= '0;
    end else begin
      if (frameStart) inFrame <= 1'b1;
      if (inValid && inLast) inFrame <= 1'b0;

      if (inValid) begin
        if (inLast) preCnt <= '0;
        else if (inPre) preCnt <= (inFrame ? preCnt : '0) + 1'b1;
      end

      if (idleStart) begin
        idleBusy <= 1'b1;
        idleCnt  <= 3'd1;
      end else if (idleBusy) begin
        idleCnt <= idleCnt + 3'd1;
        if (idleCnt == 3'd7) idleBusy <= 1'b0;
      end

      if (extEnStb) extReq <= 1'b1;
      else if (extDisStb) extReq <= 1'b0;

      if (quiet && !inValid) extActive <= extReq;
    end
  end

  // R9: input rule, no bytes while an idle header is sent
  a_r9_no_data_in_idle: assert property (@(posedge clk) disable iff (!rstN)
    idleBusy |-> !inValid);

  // R8: applied extension holds across a frame
  a_r8_hold_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    inFrame |=> $stable(extActive));

  // R2: the replaced-byte count never passes the header length
  a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rstN)
    inFrame |-> (preCnt <= PRE_MAX));

endmodule

// File: rtl/pch_datapath.sv
module pch_datapath
  import pch_pkg::*;
#(
  parameter int         SUBPORTS = 8,
  parameter logic [7:0] SOP_BYTE = 8'hFB
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStb_t    stb,
  input  logic [7:0]  inData,
  input  logic [3:0]  cfgSubport,
  input  logic        cfgPlain,
  input  logic        extActive,
  input  logic [31:0] timeQ,
  output logic        outValid,
  output logic [7:0]  outData,
  output logic        outSop,
  output logic        outLast
);

  localparam logic [3:0] SUB_MASK = 4'(SUBPORTS - 1);

  pktType_e        ty;
  extType_e        ex;
  logic [39:0]     extBits;
  logic [3:0]      subField;
  logic [7:0]      ctlByte;
  logic [7:0]      crc;
  logic [0:7][7:0] hdrNew;
  logic [0:7][7:0] hdrReg;
  logic [0:7][7:0] hdrCur;
  logic            outIsCtl;

  assign subField = cfgSubport & SUB_MASK;

  always_comb begin
    if (stb.idle) begin
      ty = PT_IDLE;  ex = EXT_NONE; extBits = '0;
    end else if (cfgPlain) begin
      ty = PT_NOHDR; ex = EXT_NONE; extBits = '0;
    end else if (extActive) begin
      ty = PT_HDR;   ex = EXT_TS;   extBits = {8'h00, timeQ};
    end else begin
      ty = PT_HDR;   ex = EXT_NONE; extBits = '0;
    end
    ctlByte = {ty, subField, ex};
    crc = crc8Step(8'h00, ctlByte);
    for (int k = 0; k < 5; k++) begin
      crc = crc8Step(crc, extBits[39 - 8*k -: 8]);
    end
    hdrNew = {SOP_BYTE, ctlByte, extBits, crc};
  end

  assign hdrCur = stb.start ? hdrNew : hdrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg   <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outSop   <= 1'b0;
      outLast  <= 1'b0;
      outIsCtl <= 1'b0;
    end else begin
      if (stb.start) hdrReg <= hdrNew;
      outValid <= stb.emit;
      outData  <= stb.hdrByte ? hdrCur[stb.byteIdx] : inData;
      outSop   <= stb.emit && stb.hdrByte && (stb.byteIdx == 3'd0);
      outLast  <= stb.emit && stb.last;
      outIsCtl <= stb.emit && stb.hdrByte && (stb.byteIdx == 3'd1);
    end
  end

  // R7: subport field of an emitted control byte is within range
  a_r7_subport_range: assert property (@(posedge clk) disable iff (!rstN)
    outIsCtl |-> (outData[5:2] < 5'(SUBPORTS)));

  // R11: start marker only on a valid byte
  a_r11_sop_valid: assert property (@(posedge clk) disable iff (!rstN)
    outSop |-> outValid);

  // R2: payload bytes pass unchanged
  a_r2_pass: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emit && !stb.hdrByte) |=> (outData == $past(inData)));

endmodule

// File: rtl/pch_inserter.sv
module pch_inserter
  import pch_pkg::*;
#(
  parameter int         SUBPORTS = 8,
  parameter logic [7:0] SOP_BYTE = 8'hFB
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  inData,
  input  logic        inLast,
  input  logic        idleReq,
  input  logic [3:0]  cfgSubport,
  input  logic        cfgPlain,
  input  logic        extEnStb,
  input  logic        extDisStb,
  input  logic [31:0] timeQ,
  output logic        outValid,
  output logic [7:0]  outData,
  output logic        outSop,
  output logic        outLast,
  output logic        extActive
);

  ctrlStb_t stb;

  pch_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inLast    (inLast),
    .idleReq   (idleReq),
    .extEnStb  (extEnStb),
    .extDisStb (extDisStb),
    .stb       (stb),
    .extActive (extActive)
  );

  pch_datapath #(
    .SUBPORTS (SUBPORTS),
    .SOP_BYTE (SOP_BYTE)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .inData     (inData),
    .cfgSubport (cfgSubport),
    .cfgPlain   (cfgPlain),
    .extActive  (extActive),
    .timeQ      (timeQ),
    .outValid   (outValid),
    .outData    (outData),
    .outSop     (outSop),
    .outLast    (outLast)
  );

  // R2: one-cycle latency for every accepted byte
  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

endmodule

// File: tb/test_pch_inserter.sv
module test_pch_inserter;

  localparam int         CLK_PERIOD = 10;
  localparam int         SUBPORTS   = 8;
  localparam logic [7:0] SOP_EXP    = 8'hFB;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid, inLast, idleReq, cfgPlain, extEnStb, extDisStb;
  logic [7:0]  inData;
  logic [3:0]  cfgSubport;
  logic [31:0] timeQ = 32'h1234_5678;
  logic        outValid, outSop, outLast, extActive;
  logic [7:0]  outData;

  int checks = 0;
  int errors = 0;

  logic [7:0] capData [64];
  logic       capSop  [64];
  logic       capLast [64];
  int         capCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) timeQ <= timeQ + 32'd5;

  pch_inserter #(.SUBPORTS(SUBPORTS), .SOP_BYTE(SOP_EXP)) i_pch_inserter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .idleReq(idleReq), .cfgSubport(cfgSubport), .cfgPlain(cfgPlain),
    .extEnStb(extEnStb), .extDisStb(extDisStb), .timeQ(timeQ),
    .outValid(outValid), .outData(outData), .outSop(outSop), .outLast(outLast),
    .extActive(extActive)
  );

  always @(negedge clk) begin
    if (outValid && capCnt < 64) begin
      capData[capCnt] = outData;
      capSop[capCnt]  = outSop;
      capLast[capCnt] = outLast;
      capCnt++;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] benchCrc(logic [7:0] crc, logic [7:0] d);
    logic [7:0] c = crc;
    for (int b = 7; b >= 0; b--) begin
      logic fb = c[7] ^ d[b];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  // sends a frame: 7 x 0x55, 0xD5, then seed+i; mode 1 changes config at byte 3,
  // mode 2 raises idleReq at byte 3, mode 3 inserts a gap after byte 4
  task automatic sendFrame(int len, logic [7:0] seed, int mode, output logic [31:0] ts);
    capCnt = 0;
    for (int i = 0; i < len; i++) begin
      extDisStb = 1'b0;
      idleReq   = 1'b0;
      if (mode == 3 && i == 5) begin
        inValid = 1'b0;
        tick();
      end
      inValid = 1'b1;
      inData  = (i < 7) ? 8'h55 : (i == 7) ? 8'hD5 : 8'(seed + i);
      inLast  = (i == len - 1);
      if (i == 0) ts = timeQ;
      if (mode == 1 && i == 3) begin
        cfgSubport = 4'd6;
        cfgPlain   = 1'b1;
        extDisStb  = 1'b1;
      end
      if (mode == 2 && i == 3) idleReq = 1'b1;
      if (mode == 1 && i == 6) chk("R8 extActive held in frame", 32'(extActive), 32'd1);
      tick();
    end
    inValid = 1'b0; inLast = 1'b0; extDisStb = 1'b0; idleReq = 1'b0;
    repeat (4) tick();
  endtask

  task automatic checkHdr(string tag, logic [1:0] ty, logic [3:0] sub, logic [1:0] ex,
                          logic [31:0] ts);
    logic [7:0] exp [8];
    logic [7:0] crc = 8'h00;
    exp[0] = SOP_EXP;
    exp[1] = {ty, sub, ex};
    exp[2] = 8'h00;
    exp[3] = (ex == 2'b01) ? ts[31:24] : 8'h00;
    exp[4] = (ex == 2'b01) ? ts[23:16] : 8'h00;
    exp[5] = (ex == 2'b01) ? ts[15:8]  : 8'h00;
    exp[6] = (ex == 2'b01) ? ts[7:0]   : 8'h00;
    for (int k = 1; k < 7; k++) crc = benchCrc(crc, exp[k]);
    exp[7] = crc;
    for (int k = 0; k < 8; k++)
      chk($sformatf("%s R6 header byte %0d", tag, k), 32'(capData[k]), 32'(exp[k]));
    chk({tag, " R11 sop on byte 0"}, 32'(capSop[0]), 32'd1);
  endtask

  task automatic checkFrame(string tag, int len, logic [7:0] seed, logic [1:0] ty,
                            logic [3:0] sub, logic [1:0] ex, logic [31:0] ts);
    int sops = 0;
    chk({tag, " R2 byte count"}, 32'(capCnt), 32'(len));
    checkHdr(tag, ty, sub, ex, ts);
    for (int k = 8; k < len; k++)
      chk($sformatf("%s R2 data byte %0d", tag, k), 32'(capData[k]), 32'(8'(seed + k)));
    for (int k = 0; k < len; k++) sops += capSop[k];
    chk({tag, " R11 single sop"}, 32'(sops), 32'd1);
    chk({tag, " R11 last on final byte"}, 32'(capLast[len-1]), 32'd1);
    chk({tag, " R11 no early last"}, 32'(capLast[len-2]), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 outValid after reset", 32'(outValid), 32'd0);
    chk("R1 outSop after reset", 32'(outSop), 32'd0);
    chk("R1 outLast after reset", 32'(outLast), 32'd0);
    chk("R1 extActive after reset", 32'(extActive), 32'd0);
  endtask

  task automatic t_no_ext();
    logic [31:0] ts;
    cfgSubport = 4'd2; cfgPlain = 1'b0;
    sendFrame(14, 8'h30, 0, ts);
    checkFrame("R4 no extension", 14, 8'h30, 2'b00, 4'd2, 2'b00, ts);
  endtask

  task automatic t_ext_ts();
    logic [31:0] ts;
    extEnStb = 1'b1; tick(); extEnStb = 1'b0;
    repeat (2) tick();
    chk("R8 extActive after enable", 32'(extActive), 32'd1);
    cfgSubport = 4'd3;
    sendFrame(12, 8'hA0, 3, ts);
    checkFrame("R3 timestamp with gap", 12, 8'hA0, 2'b00, 4'd3, 2'b01, ts);
  endtask

  task automatic t_subport_wrap();
    logic [31:0] ts;
    cfgSubport = 4'd13;
    sendFrame(12, 8'h10, 0, ts);
    checkFrame("R7 subport modulo", 12, 8'h10, 2'b00, 4'd5, 2'b01, ts);
  endtask

  task automatic t_plain();
    logic [31:0] ts;
    cfgSubport = 4'd1; cfgPlain = 1'b1;
    sendFrame(13, 8'h44, 0, ts);
    checkFrame("R5 plain mode", 13, 8'h44, 2'b01, 4'd1, 2'b00, ts);
    cfgPlain = 1'b0;
  endtask

  task automatic t_midframe_cfg();
    logic [31:0] ts;
    cfgSubport = 4'd7; cfgPlain = 1'b0;
    sendFrame(16, 8'h70, 1, ts);
    checkFrame("R10 config frozen in frame", 16, 8'h70, 2'b00, 4'd7, 2'b01, ts);
    chk("R8 extActive after frame", 32'(extActive), 32'd0);
    cfgPlain = 1'b0;
  endtask

  task automatic t_idle();
    int lasts = 0;
    cfgSubport = 4'd4;
    capCnt = 0;
    idleReq = 1'b1; tick(); idleReq = 1'b0;
    repeat (11) tick();
    chk("R9 idle byte count", 32'(capCnt), 32'd8);
    checkHdr("R9 idle header", 2'b10, 4'd4, 2'b00, 32'd0);
    for (int k = 0; k < 8; k++) lasts += capLast[k];
    chk("R11 idle last count", 32'(lasts), 32'd1);
    chk("R11 idle last on byte 7", 32'(capLast[7]), 32'd1);
  endtask

  task automatic t_idle_in_frame();
    logic [31:0] ts;
    cfgSubport = 4'd0;
    sendFrame(12, 8'h05, 2, ts);
    repeat (10) tick();
    checkFrame("R9 idle ignored in frame", 12, 8'h05, 2'b00, 4'd0, 2'b00, ts);
  endtask

  task automatic t_both_strobes();
    extEnStb = 1'b1; extDisStb = 1'b1; tick();
    extEnStb = 1'b0; extDisStb = 1'b0;
    repeat (2) tick();
    chk("R8 enable wins over disable", 32'(extActive), 32'd1);
    extDisStb = 1'b1; tick(); extDisStb = 1'b0;
    repeat (2) tick();
    chk("R8 disable applied", 32'(extActive), 32'd0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inData = '0; inLast = 1'b0; idleReq = 1'b0;
    cfgSubport = '0; cfgPlain = 1'b0; extEnStb = 1'b0; extDisStb = 1'b0;
    repeat (3) tick();
    t_reset();
    rstN = 1'b1;
    repeat (2) tick();
    t_reset();
    t_no_ext();
    t_ext_ts();
    t_subport_wrap();
    t_plain();
    t_midframe_cfg();
    t_idle();
    t_idle_in_frame();
    t_both_strobes();
    summary();
    $finish;
  end

endmodule